// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block combines three reasons for resetting a system into one stretched reset. The reasons are a supply-low indication, a manual pushbutton and a watchdog expiry request. Two supply comparator flags arrive as digital levels, one for a tight threshold (about 4.62 V) and one for a wide threshold (about 4.37 V). A tolerance select input picks which of the two flags counts. The pushbutton pin is raw and active low. It is synchronised and debounced inside the block against a 1 ms tick enable.

Every reason reloads a single stretch counter. While a level reason is present (supply low, or button held), the counter is held at its full value. After the reason goes away, the counter runs down one step per tick. The reset is released only after a full, unbroken run of ticks. A one-cycle release strobe marks the end of each reset, so that a watchdog elsewhere can restart its own count.

The active-low output stands for an open-drain pin. A value of 0 means the pin is pulled low, and a value of 1 means it is released.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1 and `rst_out_n` is 0. After `rst_n` is released, the reset stays active until HOLD_TICKS (default 300) ticks of 1 ms have passed with no new reason.
- R2: When `tol_wide` is 0, only `vlow_tight` counts as supply low. When `tol_wide` is 1, only `vlow_wide` counts. The flag that is not selected has no effect on any output.
- R3: While the selected supply flag is 1, `rst_out` is 1 from the next cycle on. Release needs HOLD_TICKS ticks in a row with the flag at 0. A dip of even one cycle reloads the count in full.
- R4: `btn_raw_n` passes through a two-stage synchroniser. A press is recognised only after the synchronised pin has been seen low on DEB_TICKS (default 10) ticks in a row. If the pin is seen high on any tick, the run is cleared, so low pulses shorter than a few ticks never cause a reset.
- R5: While a recognised press lasts, the reset stays active. After the first tick on which the pin is seen high again, the reset stays active for another HOLD_TICKS ticks.
- R6: A one-cycle pulse on `wdog_bite` makes `rst_out` 1 on the next cycle, for HOLD_TICKS ticks. A pulse that arrives while the reset is already stretching reloads the full count.
- R7: `rst_out_n` is the complement of `rst_out` on every cycle, including during reset.
- R8: `rst_release` is 1 for exactly one cycle: the first cycle in which `rst_out` is 0 after having been 1. At all other times it is 0.
- R9: The stretch count moves only on cycles where `tick_ms` is 1. Without ticks, an active reset stays active indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| tick_ms | input | 1 | One-cycle 1 ms time-base enable |
| vlow_tight | input | 1 | Supply below tight (5%) threshold |
| vlow_wide | input | 1 | Supply below wide (10%) threshold |
| tol_wide | input | 1 | 0 selects tight flag, 1 selects wide flag |
| btn_raw_n | input | 1 | Raw pushbutton pin, active low, asynchronous |
| wdog_bite | input | 1 | Single-cycle watchdog expiry request |
| rst_out | output | 1 | Stretched reset, active high |
| rst_out_n | output | 1 | Stretched reset, active low (0 = drive pin low) |
| rst_release | output | 1 | One-cycle strobe when the reset ends |

## Verification
The assertions take the following for granted about the inputs:
- The supply flags, the tolerance select and the watchdog request are synchronous to `clk`.
- `wdog_bite` is a single-cycle pulse.
- `tick_ms` is a single-cycle enable.

Only the pushbutton pin may change at any time. The stimulus respects these assumptions. Every input is changed on the falling clock edge, and ticks arrive once every four cycles from a generator that can be paused. Supply dips and watchdog pulses last exactly one cycle wherever a boundary is being tested.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

  // Tolerance choice: which comparator flag defines "supply low".
  typedef enum logic {
    TOL_TIGHT = 1'b0,
    TOL_WIDE  = 1'b1
  } tol_sel_e;

  // Reasons that feed the stretch counter.
  typedef struct packed {
    logic supply_low;
    logic button;
    logic watchdog;
  } rst_req_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int LOW_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  output logic pressed
);

  localparam int            CW   = $clog2(LOW_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(LOW_TICKS);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // Count consecutive low samples, taken on ticks only; a high sample clears the run.
  always_comb begin
    run_d = run_q;
    if (tick) begin
      if (pin_n)              run_d = '0;
      else if (run_q != FULL) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign pressed = (run_q == FULL);

  // R4: recognition follows a low sample on a tick
  p_press_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> ($past(tick) && !$past(pin_n)));

  // R4: any high sample on a tick withdraws the press
  p_high_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pin_n) |=> !pressed);

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_rst_pkg::*;
#(
  parameter int HOLD_TICKS = 300
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  rst_req_t req,
  output logic     rst_act,
  output logic     rst_act_n,
  output logic     rel_pulse
);

  localparam int            CW   = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_n_q, rel_q;
  logic          act_d, rel_d;
  logic          hold_lvl, load;

  always_comb begin
    hold_lvl = req.supply_low | req.button;
    load     = hold_lvl | req.watchdog;
    cnt_d    = cnt_q;
    if (load)                     cnt_d = FULL;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    act_d = (cnt_d != '0);
    rel_d = (cnt_q != '0) && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= FULL;
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      act_n_q <= ~act_d;
      rel_q   <= rel_d;
    end
  end

  assign rst_act   = act_q;
  assign rst_act_n = act_n_q;
  assign rel_pulse = rel_q;

  // R3 and R5: a level reason keeps the reset active
  p_level_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lvl |=> act_q);

  // R6: a watchdog request activates the reset on the next cycle
  p_wdog_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req.watchdog |=> act_q);

  // R7: the two output flops never agree
  p_pair_opposite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q != act_n_q);

  // R8: the strobe marks the first inactive cycle
  p_rel_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> (!act_q && $past(act_q)));

  // R8: the strobe lasts one cycle
  p_rel_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> !rel_q);

  // R9: without a tick or a reason the count does not move
  p_idle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 10,
  parameter int HOLD_TICKS  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic vlow_tight,
  input  logic vlow_wide,
  input  logic tol_wide,
  input  logic btn_raw_n,
  input  logic wdog_bite,
  output logic rst_out,
  output logic rst_out_n,
  output logic rst_release
);

  logic     btn_sync_n;
  logic     btn_pressed;
  logic     supply_low;
  rst_req_t req;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_raw_n),
    .q     (btn_sync_n)
  );

  supv_debounce #(.LOW_TICKS(DEB_TICKS)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_ms),
    .pin_n   (btn_sync_n),
    .pressed (btn_pressed)
  );

  always_comb begin
    supply_low     = (tol_sel_e'(tol_wide) == TOL_WIDE) ? vlow_wide : vlow_tight;
    req.supply_low = supply_low;
    req.button     = btn_pressed;
    req.watchdog   = wdog_bite;
  end

  supv_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_str (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .req       (req),
    .rst_act   (rst_out),
    .rst_act_n (rst_out_n),
    .rel_pulse (rst_release)
  );

  // R2: with the tight threshold selected, the tight flag alone triggers a reset
  p_tight_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tol_wide && vlow_tight) |=> rst_out);

  // R2: with the wide threshold selected, the wide flag alone triggers a reset
  p_wide_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tol_wide && vlow_wide) |=> rst_out);

endmodule

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;

  localparam int DEB  = 10;
  localparam int HOLD = 300;
  localparam int TDIV = 4;

  logic clk, rst_n, tick_ms, vlow_tight, vlow_wide, tol_wide, btn_raw_n, wdog_bite;
  logic rst_out, rst_out_n, rst_release;

  int    total, bad;
  bit    tick_en, timed_out;
  int    tdiv;
  string cur_req;

  // Behavioural reference state
  bit m_pipe[$];
  int m_deb, m_str;
  bit m_rst, m_rel;

  supv_reset_gen #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vlow_tight(vlow_tight),
    .vlow_wide(vlow_wide), .tol_wide(tol_wide), .btn_raw_n(btn_raw_n),
    .wdog_bite(wdog_bite), .rst_out(rst_out), .rst_out_n(rst_out_n),
    .rst_release(rst_release)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Tick generator
  always @(negedge clk) begin
    if (!tick_en) begin
      tick_ms <= 1'b0;
    end else begin
      tdiv = (tdiv + 1) % TDIV;
      tick_ms <= (tdiv == 0);
    end
  end

  // Reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = '{1'b1, 1'b1};
      m_deb = 0; m_str = HOLD; m_rst = 1'b1; m_rel = 1'b0;
    end else begin
      bit sel, held, late;
      int nd, ns;
      sel  = tol_wide ? vlow_wide : vlow_tight;
      held = sel || (m_deb == DEB);
      late = m_pipe[1];
      nd = m_deb;
      if (tick_ms) nd = late ? 0 : ((m_deb < DEB) ? m_deb + 1 : DEB);
      ns = m_str;
      if (held || wdog_bite)        ns = HOLD;
      else if (tick_ms && m_str > 0) ns = m_str - 1;
      m_rel = (m_str != 0) && (ns == 0);
      void'(m_pipe.pop_back());
      m_pipe.push_front(btn_raw_n);
      m_deb = nd; m_str = ns; m_rst = (ns != 0);
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rst_out, m_rst, cur_req);
      chk(rst_out_n, ~m_rst, "R7");
      chk(rst_release, m_rel, "R8");
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic run_seq();
    // R1: reset state and power-up stretch
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk(rst_out, 1'b1, "R1 reset state");
    chk(rst_out_n, 1'b0, "R1 reset state n");
    rst_n = 1'b1;
    wait_ticks(290);
    chk(rst_out, 1'b1, "R1 held");
    wait_ticks(15);
    chk(rst_out, 1'b0, "R1 released");

    // R2: unselected wide flag ignored
    cur_req = "R2";
    tol_wide = 1'b0; vlow_wide = 1'b1;
    wait_ticks(20);
    chk(rst_out, 1'b0, "R2 wide ignored");
    vlow_wide = 1'b0;

    // R3: supply low, dip restarts
    cur_req = "R3";
    vlow_tight = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_out, 1'b1, "R3 low active");
    wait_ticks(5);
    vlow_tight = 1'b0;
    wait_ticks(200);
    vlow_tight = 1'b1; @(negedge clk); vlow_tight = 1'b0;
    wait_ticks(200);
    chk(rst_out, 1'b1, "R3 dip restarted");
    wait_ticks(120);
    chk(rst_out, 1'b0, "R3 released");

    // R2: wide selection
    cur_req = "R2";
    tol_wide = 1'b1; vlow_tight = 1'b1;
    wait_ticks(20);
    chk(rst_out, 1'b0, "R2 tight ignored");
    vlow_tight = 1'b0; vlow_wide = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_out, 1'b1, "R2 wide selected");
    vlow_wide = 1'b0;
    wait_ticks(310);
    chk(rst_out, 1'b0, "R2 released");
    tol_wide = 1'b0;

    // R4: short press ignored
    cur_req = "R4";
    btn_raw_n = 1'b0; wait_ticks(5); btn_raw_n = 1'b1;
    wait_ticks(5);
    chk(rst_out, 1'b0, "R4 short ignored");

    // R5: long press, stretch after release
    cur_req = "R5";
    btn_raw_n = 1'b0;
    wait_ticks(15);
    chk(rst_out, 1'b1, "R5 press active");
    wait_ticks(25);
    btn_raw_n = 1'b1;
    wait_ticks(290);
    chk(rst_out, 1'b1, "R5 held after release");
    wait_ticks(15);
    chk(rst_out, 1'b0, "R5 released");

    // R6: watchdog pulse and reload
    cur_req = "R6";
    wdog_bite = 1'b1; @(negedge clk); wdog_bite = 1'b0;
    chk(rst_out, 1'b1, "R6 bite active");
    wait_ticks(200);
    wdog_bite = 1'b1; @(negedge clk); wdog_bite = 1'b0;
    wait_ticks(250);
    chk(rst_out, 1'b1, "R6 reloaded");
    wait_ticks(60);
    chk(rst_out, 1'b0, "R6 released");

    // R9: no ticks, no release
    cur_req = "R9";
    wdog_bite = 1'b1; @(negedge clk); wdog_bite = 1'b0;
    tick_en = 1'b0;
    repeat (2000) @(negedge clk);
    chk(rst_out, 1'b1, "R9 frozen without ticks");
    tick_en = 1'b1;
    wait_ticks(310);
    chk(rst_out, 1'b0, "R9 released after ticks");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; tdiv = 0; timed_out = 1'b0;
    cur_req = "R1";
    rst_n = 1'b0; tick_en = 1'b1; tick_ms = 1'b0;
    vlow_tight = 1'b0; vlow_wide = 1'b0; tol_wide = 1'b0;
    btn_raw_n = 1'b1; wdog_bite = 1'b0;
    fork
      run_seq();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule